// File: doc/BRIEF.md
# Write-Protect Gate for Power-Management Bus Commands

This block sits between a power-management bus command decoder and the configuration register file. It decides, for every write command, whether the target register may be updated. Two sources of protection are merged. One is an active-high hardware protect pin. The other is the software write-protect register, which this block holds itself. Whichever of the two is more restrictive governs each write.

The decoder presents a command code, a one-cycle write strobe and the data byte. One cycle later the block answers with exactly one pulse. An accept pulse lets the register file commit the write. A reject pulse feeds the communication-fault status bit. Writes that carry the write-protect command code update the block's own register. Such a write is accepted at every protection level, as long as its value is one of the four supported settings. Reads never reach this block, so they are never blocked.

Command codes (defaults, all parameters): PAGE 0x00, OPERATION 0x01, ON_OFF_CONFIG 0x02, CLEAR_FAULTS 0x03, WRITE_PROTECT 0x10, STORE_USER_ALL 0x15, VOUT_COMMAND 0x21, page-mask 0xE4.

Top module: `pmbus_wp_filter`

## Requirements
- R1: After reset `wp_level` is 0x00, and `wr_ok` and `wr_deny` are both low.
- R2: A cycle with `wr_stb` high is followed, in the next cycle, by exactly one of `wr_ok` or `wr_deny` high for one cycle. Without a strobe, both stay low.
- R3: With `wp_level` 0x00 and `wp_pin` low, every write is accepted.
- R4: With `wp_level` 0x80, only writes to command 0x10 are accepted, whatever the pin level.
- R5: With `wp_level` 0x40, only commands 0x10, 0x00 and 0x01 are accepted, whatever the pin level.
- R6: With `wp_level` 0x20 and `wp_pin` low, only commands 0x10, 0x00, 0x01, 0x02 and 0x21 are accepted.
- R7: With `wp_pin` high and `wp_level` 0x00 or 0x20, only commands 0x10, 0x00, 0x01, 0x03, 0x15 and 0xE4 are accepted. So with 0x20 and the pin high, 0x02 and 0x21 are rejected and 0x03 is accepted.
- R8: Strictness is ranked 0x80 > 0x40 > pin > 0x20 > 0x00, and the strictest active source decides. With the pin high and the register at 0x80, a write to 0x00 is rejected.
- R9: A write to 0x10 with data 0x00, 0x20, 0x40 or 0x80 is accepted at every level. `wp_level` takes the new value in the same cycle as the accept pulse, and that value governs the next strobe.
- R10: A write to 0x10 with any other data is rejected, and `wp_level` keeps its value.
- R11: Cycles without a strobe never change `wp_level`, whatever the command, data and pin inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 8 | Command code of the current transaction |
| wr_data | input | 8 | Write data byte (used for the write-protect command) |
| wr_stb | input | 1 | One-cycle write request strobe |
| wp_pin | input | 1 | Hardware write-protect pin, active high |
| wr_ok | output | 1 | Write accepted, one-cycle pulse |
| wr_deny | output | 1 | Write rejected, one-cycle pulse for fault reporting |
| wp_level | output | 8 | Current software protection setting |

## Verification
On every cycle, assertions check the following:
- the one-pulse-per-strobe handshake;
- that `wp_level` only holds legal settings and only moves on an accepted protect write;
- that the 0x80 lock rejects every other command;
- that protect writes with legal data always pass.

The full permission table for each combination of pin and register, including the pin-versus-0x20 ranking, is shown only by the bench's scenarios. Those scenarios mix random commands and directed corner cases against a rank-based model.

// File: rtl/pmbus_wp_filter.sv
module pmbus_wp_filter #(
  parameter logic [7:0] CMD_PAGE    = 8'h00,
  parameter logic [7:0] CMD_OPER    = 8'h01,
  parameter logic [7:0] CMD_ONOFF   = 8'h02,
  parameter logic [7:0] CMD_CLRF    = 8'h03,
  parameter logic [7:0] CMD_WPROT   = 8'h10,
  parameter logic [7:0] CMD_STORE   = 8'h15,
  parameter logic [7:0] CMD_VOUT    = 8'h21,
  parameter logic [7:0] CMD_PGMASK  = 8'hE4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_code,
  input  logic [7:0] wr_data,
  input  logic       wr_stb,
  input  logic       wp_pin,
  output logic       wr_ok,
  output logic       wr_deny,
  output logic [7:0] wp_level
);

  logic is_wp, data_legal, set_a, set_b, set_pin, reg_ok, reg_strict, allow;

  assign is_wp      = (cmd_code == CMD_WPROT);
  assign data_legal = (wr_data == 8'h00) || (wr_data == 8'h20) ||
                      (wr_data == 8'h40) || (wr_data == 8'h80);

  assign set_a   = is_wp || (cmd_code == CMD_PAGE) || (cmd_code == CMD_OPER);
  assign set_b   = set_a || (cmd_code == CMD_ONOFF) || (cmd_code == CMD_VOUT);
  assign set_pin = set_a || (cmd_code == CMD_CLRF) || (cmd_code == CMD_STORE) ||
                   (cmd_code == CMD_PGMASK);

  always_comb begin
    case (wp_level)
      8'h80:   reg_ok = is_wp;
      8'h40:   reg_ok = set_a;
      8'h20:   reg_ok = set_b;
      default: reg_ok = 1'b1;
    endcase
  end

  assign reg_strict = wp_level[7] | wp_level[6];
  assign allow = is_wp ? data_legal :
                 (wp_pin && !reg_strict) ? set_pin : reg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ok    <= 1'b0;
      wr_deny  <= 1'b0;
      wp_level <= 8'h00;
    end else begin
      wr_ok   <= wr_stb && allow;
      wr_deny <= wr_stb && !allow;
      if (wr_stb && is_wp && data_legal)
        wp_level <= wr_data;
    end
  end

  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (wr_ok ^ wr_deny));
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (!wr_ok && !wr_deny));
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wp_level == 8'h80 && cmd_code != CMD_WPROT) |=> wr_deny);
  p_wp_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && is_wp && data_legal) |=> (wr_ok && wp_level == $past(wr_data)));
  p_wp_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && is_wp && !data_legal) |=> (wr_deny && $stable(wp_level)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(wp_level));
  p_legal_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_level == 8'h00) || (wp_level == 8'h20) || (wp_level == 8'h40) || (wp_level == 8'h80));

endmodule

// File: tb/pmbus_wp_filter_test.sv
`timescale 1ns/1ps
module pmbus_wp_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic wr_stb = 1'b0;
  logic wp_pin = 1'b0;
  logic wr_ok, wr_deny;
  logic [7:0] wp_level;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] m_lvl = 8'h00;

  always #2 clk = ~clk;

  pmbus_wp_filter uut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .wr_data(wr_data),
    .wr_stb(wr_stb), .wp_pin(wp_pin), .wr_ok(wr_ok), .wr_deny(wr_deny),
    .wp_level(wp_level)
  );

  function automatic int rank_of(input logic [7:0] lvl, input logic pin);
    int r;
    r = (lvl == 8'h80) ? 4 : (lvl == 8'h40) ? 3 : (lvl == 8'h20) ? 1 : 0;
    if (pin && r < 2) r = 2;
    return r;
  endfunction

  function automatic logic legal(input logic [7:0] d);
    return d == 8'h00 || d == 8'h20 || d == 8'h40 || d == 8'h80;
  endfunction

  function automatic logic exp_ok(input logic [7:0] c, input logic [7:0] d,
                                  input logic [7:0] lvl, input logic pin);
    if (c == 8'h10) return legal(d);
    case (rank_of(lvl, pin))
      4: return 1'b0;
      3: return c == 8'h00 || c == 8'h01;
      2: return c == 8'h00 || c == 8'h01 || c == 8'h03 || c == 8'h15 || c == 8'hE4;
      1: return c == 8'h00 || c == 8'h01 || c == 8'h02 || c == 8'h21;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag(input logic [7:0] c, input logic [7:0] lvl, input logic pin);
    if (c == 8'h10) return "R9/R10";
    case (rank_of(lvl, pin))
      4: return pin ? "R8" : "R4";
      3: return "R5";
      2: return "R7";
      1: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] c, input logic [7:0] d, input logic pin);
    logic e;
    string t;
    e = exp_ok(c, d, m_lvl, pin);
    t = tag(c, m_lvl, pin);
    @(negedge clk);
    cmd_code = c; wr_data = d; wp_pin = pin; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (c == 8'h10 && legal(d)) m_lvl = d;
    check({t, " ok/deny"}, {7'd0, wr_ok, wr_deny}, {7'd0, e, !e});
    check({t, " level"}, {1'b0, wp_level}, {1'b0, m_lvl});
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {wr_ok, wp_level}, 9'h000);
    check("R1 deny", {8'd0, wr_deny}, 9'h0);

    do_wr(8'h21, 8'h5A, 1'b0);
    do_wr(8'hE4, 8'h00, 1'b0);
    do_wr(8'h10, 8'h80, 1'b0);
    do_wr(8'h00, 8'h00, 1'b1);
    do_wr(8'h10, 8'h00, 1'b1);
    do_wr(8'h10, 8'h20, 1'b0);
    do_wr(8'h03, 8'h00, 1'b1);
    do_wr(8'h21, 8'h00, 1'b1);
    do_wr(8'h02, 8'h00, 1'b0);
    do_wr(8'h10, 8'h30, 1'b0);
    do_wr(8'h10, 8'h40, 1'b1);
    do_wr(8'h15, 8'h00, 1'b1);
    do_wr(8'h01, 8'h00, 1'b1);

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmd_code = 8'h10; wr_data = 8'h80; wp_pin = k[0]; wr_stb = 1'b0;
    end
    @(negedge clk);
    check("R11 idle level", {1'b0, wp_level}, {1'b0, m_lvl});
    check("R2 idle pulses", {7'd0, wr_ok, wr_deny}, 9'h0);

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] c, d;
      case ($urandom_range(0, 9))
        0: c = 8'h00; 1: c = 8'h01; 2: c = 8'h02; 3: c = 8'h03;
        4: c = 8'h10; 5: c = 8'h15; 6: c = 8'h21; 7: c = 8'hE4;
        8: c = 8'h10;
        default: c = 8'($urandom);
      endcase
      case ($urandom_range(0, 4))
        0: d = 8'h00; 1: d = 8'h20; 2: d = 8'h40; 3: d = 8'h80;
        default: d = 8'($urandom);
      endcase
      do_wr(c, d, 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule